// File: doc/BRIEF.md
# Line Channel Power-Up Sequencer

This block controls when the drivers of four line channels are switched on. Capacitive line loads draw an inrush current at switch-on and hold the driver in current limit for a while. Switching several channels on together therefore heats the die. The block collects activation requests and queues them. It switches on one channel at a time and waits until that channel has left current limit before it starts the next one.

All sequencing state advances only on cycles where the slow-clock enable `tick` is high; the enable nominally marks an 8 kHz rate. When several channels are waiting, the lowest channel index is always served first, whatever order the requests arrived in. A dropped request switches its driver off at once, in the same cycle. A strap input bypasses the sequencer so that the drivers follow the requests directly. A thermal hold input stops new requests from entering the queue. Requests that are already queued are still served.

Top module: `line_pwrup_seq`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) empties the queue and leaves `drv_en` and `pwrup` all zero after that edge.
- R2: With `seq_off` low, a channel whose `act_req` bit is high enters the queue at the next tick. If no channel is powering up at the tick after that, its `drv_en` bit and its `pwrup` bit rise together after that tick.
- R3: At most one `pwrup` bit is high at any time, and at most one new `drv_en` bit rises per tick.
- R4: A `pwrup` bit falls at the first tick after its grant at which that channel's `ilim` bit is low. The next queued channel is granted at the tick that follows.
- R5: Among queued channels the lowest index is granted first. Requests that arrive as 2, then 1 and 3, then 0 are granted in the order 2, 0, 1, 3.
- R6: Once a channel's `pwrup` bit has fallen, that channel's `ilim` bit has no further effect on the sequence.
- R7: If the channel powering up keeps `ilim` high, no other channel is granted. The stall ends when that channel's request drops, and the next queued channel is granted at the first tick after the drop.
- R8: A low `act_req` bit clears that channel's `drv_en` and `pwrup` bits combinationally in the same cycle, without waiting for a tick. It also removes the channel from the queue.
- R9: With `seq_off` high, `drv_en` equals `act_req` combinationally, `pwrup` stays all zero and the queue is emptied.
- R10: While `hold_new` is high, no new request enters the queue. A channel that is already queued is still granted. A request held through the hold enters the queue at the first tick after `hold_new` falls.
- R11: Apart from R8 and R9, `drv_en` and `pwrup` change only after a clock edge at which `tick` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Slow-clock enable, one cycle wide per sequencer step |
| seq_off | input | 1 | Strap: 1 bypasses the sequencer |
| hold_new | input | 1 | Thermal hold: 1 blocks new requests from entering the queue |
| act_req | input | N_CH | Per-channel activation request, 1 = on |
| ilim | input | N_CH | Per-channel current-limit flag, 1 = in limit |
| drv_en | output | N_CH | Per-channel driver enable |
| pwrup | output | N_CH | Per-channel power-up-in-progress flag |

## Verification
The bound checker checks the following on every cycle:
- at most one power-up flag is high;
- a power-up flag is never high without its driver enable;
- no driver enable is high without its request;
- no enable rises except after a tick;
- at most one enable rises per tick;
- the flags stay clear in bypass.

Other behaviour depends on the order of arrivals and of limit events, so only the bench scenarios can show it. This covers lowest-index-first ordering, the one-tick gap between a flag falling and the next grant, a stall on a channel that stays in limit, a later limit event that changes nothing, and queued grants that continue under thermal hold.

// File: rtl/lps_pkg.sv
// Shared definitions for the line power-up sequencer.
// Assumes: one entry of per-channel state per line channel.
package lps_pkg;

    localparam int LPS_DEF_CH = 4;

    // Sequencing state of one channel.
    typedef struct packed {
        logic pend;   // waiting in the queue
        logic on;     // driver granted
        logic pwrup;  // granted and still in its inrush phase
    } lps_chan_t;

endpackage

// File: rtl/lps_pick.sv
// Lowest-index-first selector: grants the lowest set bit of `pend`
// when `en` is high. Assumes `pend` is stable for the cycle.
module lps_pick #(
    parameter int N = 4
) (
    input  logic         en,
    input  logic [N-1:0] pend,
    output logic [N-1:0] grant
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    // Ripple chain: a bit wins only if no lower bit is pending.
    for (genvar i = 0; i < N; i++) begin : g_pick
        assign grant[i]  = en & pend[i] & ~seen[i];
        assign seen[i+1] = seen[i] | pend[i];
    end
endmodule

// File: rtl/lps_chan.sv
// One channel of the sequencer: holds the queue bit, the granted bit and
// the power-up flag. Assumes `grant` comes only for a queued channel, and
// that the channel's current-limit flag is valid by the tick after its grant.
module lps_chan
    import lps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic seq_off,
    input  logic hold_new,
    input  logic req,
    input  logic ilim,
    input  logic grant,
    output logic pend_o,
    output logic pwrup_raw,
    output logic drv_en,
    output logic pwrup
);
    lps_chan_t st;

    // State update: reset and bypass clear, a drop clears, otherwise step on tick.
    always_ff @(posedge clk) begin
        if (!rst_n || seq_off) begin
            st <= '0;
        end else if (!req) begin
            st <= '0;
        end else if (tick) begin
            if (grant) begin
                st.on    <= 1'b1;
                st.pend  <= 1'b0;
                st.pwrup <= 1'b1;
            end else begin
                if (st.pwrup && !ilim) begin
                    st.pwrup <= 1'b0;
                end
                if (!st.on && !st.pend && !hold_new) begin
                    st.pend <= 1'b1;
                end
            end
        end
    end

    // Output masking: a dropped request takes effect in the same cycle.
    always_comb begin
        drv_en = seq_off ? req : (st.on & req);
        pwrup  = st.pwrup & req & ~seq_off;
    end

    assign pend_o    = st.pend;
    assign pwrup_raw = st.pwrup;
endmodule

// File: rtl/line_pwrup_seq.sv
// Top of the line power-up sequencer. Queues channel activation requests
// and grants them one per tick, lowest index first, only when no channel
// is in its inrush phase. Assumes `tick` is a one-cycle enable from a slow
// clock and that all inputs are synchronous to `clk`.
module line_pwrup_seq
    import lps_pkg::*;
#(
    parameter int N_CH = LPS_DEF_CH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            seq_off,
    input  logic            hold_new,
    input  logic [N_CH-1:0] act_req,
    input  logic [N_CH-1:0] ilim,
    output logic [N_CH-1:0] drv_en,
    output logic [N_CH-1:0] pwrup
);
    logic [N_CH-1:0] pend;
    logic [N_CH-1:0] pwrup_raw;
    logic [N_CH-1:0] grant;
    logic            busy;
    logic            grant_en;

    // Grant window: a tick with no channel still powering up.
    always_comb begin
        busy     = |pwrup_raw;
        grant_en = tick & ~busy & ~seq_off;
    end

    lps_pick #(.N(N_CH)) u_pick (
        .en    (grant_en),
        .pend  (pend),
        .grant (grant)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        lps_chan u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .seq_off   (seq_off),
            .hold_new  (hold_new),
            .req       (act_req[c]),
            .ilim      (ilim[c]),
            .grant     (grant[c]),
            .pend_o    (pend[c]),
            .pwrup_raw (pwrup_raw[c]),
            .drv_en    (drv_en[c]),
            .pwrup     (pwrup[c])
        );
    end
endmodule

// File: rtl/lps_chk.sv
// Property checker for line_pwrup_seq, attached with bind.
// Assumes reset is asserted from time zero.
module lps_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         seq_off,
    input logic [N-1:0] act_req,
    input logic [N-1:0] drv_en,
    input logic [N-1:0] pwrup
);
    // R3
    one_pwrup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pwrup));

    // R3
    one_grant_per_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_off && !$past(seq_off) |-> $countones(drv_en & ~$past(drv_en)) <= 1);

    // R2
    pwrup_has_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwrup & ~drv_en) == '0);

    // R8
    drv_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en & ~act_req) == '0);

    // R11
    rise_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_off && !$past(seq_off) && !$past(tick) |-> (drv_en & ~$past(drv_en)) == '0);

    // R9
    bypass_no_pwrup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_off |-> pwrup == '0);
endmodule

bind line_pwrup_seq lps_chk #(.N(N_CH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .seq_off (seq_off),
    .act_req (act_req),
    .drv_en  (drv_en),
    .pwrup   (pwrup)
);

// File: tb/line_pwrup_seq_tb.sv
// Self-checking bench for line_pwrup_seq: a vector table walked tick by
// tick, then directed tests for reset, drops, stalls, hold and bypass.
module line_pwrup_seq_tb;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         seq_off = 1'b0;
    logic         hold_new = 1'b0;
    logic [N-1:0] act_req = '0;
    logic [N-1:0] ilim = '0;
    logic [N-1:0] drv_en;
    logic [N-1:0] pwrup;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    line_pwrup_seq #(.N_CH(N)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .seq_off  (seq_off),
        .hold_new (hold_new),
        .act_req  (act_req),
        .ilim     (ilim),
        .drv_en   (drv_en),
        .pwrup    (pwrup)
    );

    // Row fields: {act_req, ilim, expected drv_en, expected pwrup}, one tick each.
    localparam logic [15:0] VEC [12] = '{
        16'b0100_0000_0000_0000, // R2 ch2 queued
        16'b0100_0100_0100_0100, // R2 ch2 granted
        16'b1110_0100_0100_0100, // R3 ch1,ch3 queued, ch2 still in limit
        16'b1111_0100_0100_0100, // R3 ch0 queued
        16'b1111_0000_0100_0000, // R4 ch2 leaves limit
        16'b1111_0001_0101_0001, // R5 ch0 first
        16'b1111_0101_0101_0001, // R6 ch2 back in limit, no effect
        16'b1111_0100_0101_0000, // R4 ch0 leaves limit
        16'b1111_0110_0111_0010, // R5 ch1 next
        16'b1111_0000_0111_0000, // R4
        16'b1111_1000_1111_1000, // R5 ch3 last
        16'b1111_0000_1111_0000  // R4
    };

    task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // Called at a falling edge: one tick pulse spanning one rising edge.
    task automatic step();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        act_req = '0;
        ilim = '0;
        hold_new = 1'b0;
        seq_off = 1'b0;
        idle(2);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        chk("R1 drv_en after reset", drv_en, 4'b0000);
        chk("R1 pwrup after reset", pwrup, 4'b0000);

        for (int r = 0; r < 12; r++) begin
            act_req = VEC[r][15:12];
            ilim    = VEC[r][11:8];
            step();
            chk($sformatf("table row %0d drv_en", r), drv_en, VEC[r][7:4]);
            chk($sformatf("table row %0d pwrup", r), pwrup, VEC[r][3:0]);
        end

        // R8: drop ch2 with no tick, effect in the same cycle
        act_req = 4'b1011;
        #1;
        chk("R8 same-cycle drop", drv_en, 4'b1011);
        idle(3);
        chk("R8 stays off", drv_en, 4'b1011);

        // R1: reset while channels are on
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-run reset", drv_en, 4'b0000);
        rst_n = 1'b1;
        act_req = '0;
        @(negedge clk);

        // R11: request without tick is not served
        do_reset();
        act_req = 4'b0001;
        idle(6);
        chk("R11 no tick no grant", drv_en, 4'b0000);

        // R7: stall on a channel that stays in limit
        act_req = 4'b0011;
        ilim = 4'b0001;
        step();
        step();
        chk("R7 ch0 granted", drv_en, 4'b0001);
        step();
        step();
        step();
        chk("R7 stall drv_en", drv_en, 4'b0001);
        chk("R7 stall pwrup", pwrup, 4'b0001);
        act_req = 4'b0010;
        ilim = 4'b0010;
        #1;
        chk("R7 drop clears drv_en", drv_en, 4'b0000);
        chk("R7 drop clears pwrup", pwrup, 4'b0000);
        @(negedge clk);
        step();
        chk("R7 ch1 granted after drop", drv_en, 4'b0010);
        chk("R7 ch1 pwrup", pwrup, 4'b0010);

        // R10: new requests held off while hold_new is high
        do_reset();
        hold_new = 1'b1;
        act_req = 4'b0100;
        step();
        step();
        chk("R10 held request not served", drv_en, 4'b0000);
        hold_new = 1'b0;
        step();
        chk("R10 queued after release", drv_en, 4'b0000);
        ilim = 4'b0100;
        step();
        chk("R10 granted after release", drv_en, 4'b0100);

        // R10: already-queued request still granted during hold
        do_reset();
        act_req = 4'b0011;
        ilim = 4'b0001;
        step();
        step();
        chk("R10 ch0 granted", drv_en, 4'b0001);
        hold_new = 1'b1;
        ilim = 4'b0000;
        step();
        ilim = 4'b0010;
        step();
        chk("R10 queued ch1 granted under hold", drv_en, 4'b0011);
        chk("R10 ch1 pwrup under hold", pwrup, 4'b0010);

        // R9: bypass strap, drivers follow requests
        do_reset();
        seq_off = 1'b1;
        act_req = 4'b1010;
        #1;
        chk("R9 bypass drv_en", drv_en, 4'b1010);
        chk("R9 bypass pwrup", pwrup, 4'b0000);
        ilim = 4'b1010;
        step();
        chk("R9 bypass pwrup after tick", pwrup, 4'b0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule